// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block is the control state machine behind a two-bit conversion-mode field. Software writes a mode code; the controller turns it into power, start and sequencing controls for an external converter core. It powers the converter up on demand and holds off the first conversion until a fixed settling interval has elapsed. It then issues one start pulse per conversion sequence and raises a one-cycle data-ready pulse each time the converter reports a finished sequence.

Three request modes are supported: a single sequence, continuous back-to-back sequences, and power-down. A fourth code, idle, keeps the converter powered without converting, so the next request starts at once. A single-sequence or continuous request made while the converter is off powers it up, waits out the settling time and then converts, with no second write. A request made while the converter is already on starts on the next cycle. The settling interval is a cycle count derived from the clock frequency and the settling time in microseconds.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the power enable is low, start and data-ready are low, and the mode field reads back 2'b11 (powered down).
- R2: Writing 2'b01 while powered down raises the power enable on the cycle after the write and then runs exactly one conversion sequence (one start pulse, one data-ready pulse) with no further write.
- R3: After the power enable rises, no start pulse is issued until SETTLE_CYCLES clock cycles have passed; the first start follows exactly SETTLE_CYCLES cycles after power enable rises.
- R4: Writing 2'b01 while powered and idle produces a start pulse on the cycle right after the write, with no settling wait.
- R5: Writing 2'b10 while powered down powers up, waits the settling time, then starts a new sequence on the cycle after each conversion-done, repeatedly.
- R6: Code 2'b00 means idle-powered: written while on, the converter stays powered and no new sequence starts once the current one ends; written while powered down, it is ignored (mode stays 2'b11, power stays low).
- R7: When a single sequence completes, the controller returns to idle-powered and the mode field reads back 2'b00.
- R8: Writing 2'b11 drops the power enable on the cycle after the write, aborts an active conversion without a data-ready pulse, and cancels any settling count, so the next power-up waits the full settling time again.
- R9: Data-ready is a one-cycle pulse on the cycle after conversion-done is seen during a conversion; conversion-done at any other time is ignored.
- R10: The start output is a one-cycle pulse and is never high while the power enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 2 | Mode code written: 00 idle, 01 single, 10 continuous, 11 off |
| mode_rd | output | 2 | Current mode field readback |
| adc_pwr_en | output | 1 | Converter power enable |
| adc_start | output | 1 | One-cycle start-of-sequence pulse to the converter |
| adc_done | input | 1 | Converter reports that the current sequence finished |
| data_rdy | output | 1 | One-cycle pulse when a sequence result is ready |

## Verification
The hardest situation to reach is a power-down request that lands while a settling count is part-way through, followed by a fresh request whose settling must restart from zero rather than resume. The stimulus writes a single-sequence request from the off state, writes power-down about half-way through the settling window, then writes the request again and measures the gap from power enable to start. A second hard case is an abort that overlaps an in-flight conversion whose done pulse still arrives later; the behavioural converter stand-in keeps counting after the abort so that stray done pulse reaches the block while it is off.

// File: rtl/adc_seq_pkg.sv
// Package: shared codes for the conversion sequence controller.
// Assumes the mode field is two bits wide and that its encodings are fixed.
package adc_seq_pkg;

    // Mode field encodings, as seen by software through the register map.
    typedef enum logic [1:0] {
        MODE_IDLE   = 2'b00,
        MODE_SINGLE = 2'b01,
        MODE_CONT   = 2'b10,
        MODE_OFF    = 2'b11
    } seq_mode_e;

    // Controller phases.
    typedef enum logic [2:0] {
        PH_OFF    = 3'd0,
        PH_SETTLE = 3'd1,
        PH_IDLE   = 3'd2,
        PH_START  = 3'd3,
        PH_CONV   = 3'd4
    } seq_phase_e;

    // True when the code asks the converter to run.
    function automatic logic wants_run(input logic [1:0] code);
        return (code == MODE_SINGLE) || (code == MODE_CONT);
    endfunction

endpackage

// File: rtl/adc_mode_field.sv
// Module: adc_mode_field
// Holds the two-bit mode field. A write of the idle code while the field
// holds the off code is dropped. When the sequencer reports that a single
// sequence finished, the field falls back to idle unless a write lands in
// the same cycle, which wins. Exposes both the held and the next value so
// the sequencer reacts in the same edge as the field.
module adc_mode_field
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    input  logic       single_done,
    output logic [1:0] mode_q,
    output logic [1:0] mode_nxt
);

    logic accept;

    // Qualify the write: idle is not a legal request while powered down.
    always_comb begin
        accept = wr_en && !((wr_data == MODE_IDLE) && (mode_q == MODE_OFF));
    end

    // Pick the next field value: write first, then single-done fallback.
    always_comb begin
        if (accept) begin
            mode_nxt = wr_data;
        end else if (single_done) begin
            mode_nxt = MODE_IDLE;
        end else begin
            mode_nxt = mode_q;
        end
    end

    // Field storage, off after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
        end else begin
            mode_q <= mode_nxt;
        end
    end

endmodule

// File: rtl/adc_settle_timer.sv
// Module: adc_settle_timer
// Counts clock cycles while run is high and flags the last cycle of the
// settling window. Dropping run clears the count at once, so a cancelled
// window always restarts from zero. Assumes CYCLES >= 1.
module adc_settle_timer #(
    parameter int CYCLES = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    // Elapsed-cycle counter, held at zero while not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Terminal-count flag, valid only while running.
    always_comb begin
        expired = run && (cnt == LAST);
    end

endmodule

// File: rtl/adc_seq_fsm.sv
// Module: adc_seq_fsm
// Sequencer for the converter. Reacts to the next mode value, so a write
// takes effect on the same edge that stores it. Off forces power down from
// any phase. A run request from off goes through the settling phase; from
// idle it starts directly. Assumes adc_done is a single-cycle pulse.
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_q,
    input  logic [1:0] mode_nxt,
    input  logic       settle_expired,
    input  logic       conv_done,
    output logic       settle_run,
    output logic       single_done,
    output logic       pwr_en,
    output logic       start,
    output logic       rdy
);

    seq_phase_e phase, phase_nxt;
    logic       rdy_nxt;

    // A finished single sequence clears the field back to idle.
    always_comb begin
        single_done = (phase == PH_CONV) && conv_done && (mode_q == MODE_SINGLE);
    end

    // Next-phase selection.
    always_comb begin
        phase_nxt = phase;
        if (mode_nxt == MODE_OFF) begin
            phase_nxt = PH_OFF;
        end else begin
            unique case (phase)
                PH_OFF: begin
                    if (wants_run(mode_nxt)) phase_nxt = PH_SETTLE;
                end
                PH_SETTLE: begin
                    if (settle_expired) begin
                        phase_nxt = wants_run(mode_nxt) ? PH_START : PH_IDLE;
                    end
                end
                PH_IDLE: begin
                    if (wants_run(mode_nxt)) phase_nxt = PH_START;
                end
                PH_START: begin
                    phase_nxt = PH_CONV;
                end
                PH_CONV: begin
                    if (conv_done) begin
                        phase_nxt = wants_run(mode_nxt) ? PH_START : PH_IDLE;
                    end
                end
                default: phase_nxt = PH_OFF;
            endcase
        end
    end

    // Result-ready decision: a done inside a conversion that is not aborted.
    always_comb begin
        rdy_nxt = (phase == PH_CONV) && conv_done && (mode_nxt != MODE_OFF);
    end

    // Phase and ready-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_OFF;
            rdy   <= 1'b0;
        end else begin
            phase <= phase_nxt;
            rdy   <= rdy_nxt;
        end
    end

    // Decoded controls toward the converter and the timer.
    always_comb begin
        pwr_en     = (phase != PH_OFF);
        start      = (phase == PH_START);
        settle_run = (phase == PH_SETTLE);
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
// Module: adc_seq_ctrl (top)
// Conversion sequence controller: mode field, settling timer and sequencer.
// The settling window is CLK_FREQ_HZ / 1 MHz * SETTLE_US cycles; assumes
// CLK_FREQ_HZ is a whole number of MHz.
module adc_seq_ctrl #(
    parameter int CLK_FREQ_HZ = 250_000_000,
    parameter int SETTLE_US   = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [1:0] mode_wdata,
    output logic [1:0] mode_rd,
    output logic       adc_pwr_en,
    output logic       adc_start,
    input  logic       adc_done,
    output logic       data_rdy
);

    localparam int CYC_PER_US    = CLK_FREQ_HZ / 1_000_000;
    localparam int SETTLE_RAW    = CYC_PER_US * SETTLE_US;
    localparam int SETTLE_CYCLES = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;

    logic [1:0] mode_q;
    logic [1:0] mode_nxt;
    logic       single_done;
    logic       settle_run;
    logic       settle_expired;

    adc_mode_field u_field (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (mode_wr),
        .wr_data     (mode_wdata),
        .single_done (single_done),
        .mode_q      (mode_q),
        .mode_nxt    (mode_nxt)
    );

    adc_settle_timer #(
        .CYCLES (SETTLE_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (settle_run),
        .expired (settle_expired)
    );

    adc_seq_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_q         (mode_q),
        .mode_nxt       (mode_nxt),
        .settle_expired (settle_expired),
        .conv_done      (adc_done),
        .settle_run     (settle_run),
        .single_done    (single_done),
        .pwr_en         (adc_pwr_en),
        .start          (adc_start),
        .rdy            (data_rdy)
    );

    // Readback of the held mode field.
    always_comb begin
        mode_rd = mode_q;
    end

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Module: adc_seq_ctrl_chk
// Port-level properties of the sequence controller, attached by bind.
// Tracks powered cycles with a saturating counter to check the settling
// window without deep $past.
module adc_seq_ctrl_chk #(
    parameter int SETTLE_CYCLES = 25000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_wr,
    input logic [1:0] mode_wdata,
    input logic [1:0] mode_rd,
    input logic       adc_pwr_en,
    input logic       adc_start,
    input logic       adc_done,
    input logic       data_rdy
);

    localparam int PW = $clog2(SETTLE_CYCLES + 2);
    localparam logic [PW-1:0] PMAX = PW'(SETTLE_CYCLES);

    logic [PW-1:0] pwr_cnt;

    // Cycles since power enable rose, saturating at the settling length.
    always_ff @(posedge clk) begin
        if (!rst_n || !adc_pwr_en) begin
            pwr_cnt <= '0;
        end else if (pwr_cnt != PMAX) begin
            pwr_cnt <= pwr_cnt + 1'b1;
        end
    end

    assert_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_wdata == 2'b01 && mode_rd == 2'b11) |=> adc_pwr_en);

    assert_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (pwr_cnt == PMAX));

    assert_off_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_wdata == 2'b00 && mode_rd == 2'b11) |=> (mode_rd == 2'b11 && !adc_pwr_en));

    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_wdata == 2'b11) |=> (!adc_pwr_en && !adc_start && !data_rdy));

    assert_rdy_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        data_rdy |=> !data_rdy);

    assert_rdy_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        data_rdy |-> $past(adc_done));

    assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    assert_start_powered_R10: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> adc_pwr_en);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .mode_rd    (mode_rd),
    .adc_pwr_en (adc_pwr_en),
    .adc_start  (adc_start),
    .adc_done   (adc_done),
    .data_rdy   (data_rdy)
);

// File: tb/adc_seq_ctrl_tb.sv
// Bench for adc_seq_ctrl: behavioural cycle model compared every clock,
// plus directed checks per requirement. Settling shortened to 100 cycles.
module adc_seq_ctrl_tb;

    localparam int N   = 100;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [1:0] mode_wdata = 2'b00;
    logic [1:0] mode_rd;
    logic       adc_pwr_en;
    logic       adc_start;
    logic       adc_done = 1'b0;
    logic       data_rdy;

    adc_seq_ctrl #(.CLK_FREQ_HZ(1_000_000), .SETTLE_US(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .mode_rd(mode_rd), .adc_pwr_en(adc_pwr_en), .adc_start(adc_start),
        .adc_done(adc_done), .data_rdy(data_rdy)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int n_start = 0;
    int n_rdy = 0;
    int rise_cyc = 0;
    int last_gap = -1;
    bit gap_armed = 0;
    bit prev_pwr = 0;
    bit finished = 0;
    int stray_req = 0;
    int stray_seen = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Reference model state: 0 off, 1 settling, 2 idle, 3 starting, 4 converting.
    int m_ph = 0;
    int m_mode = 3;
    int m_cnt = 0;
    bit m_rdy = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_mode = 3; m_cnt = 0; m_rdy = 0;
        end else begin
            int want, old_ph;
            bit take, fin;
            old_ph = m_ph;
            take = mode_wr && !(mode_wdata == 2'b00 && m_mode == 3);
            fin = (m_ph == 4) && adc_done && (m_mode == 1);
            want = take ? int'(mode_wdata) : (fin ? 0 : m_mode);
            m_rdy = (m_ph == 4) && adc_done && (want != 3);
            if (want == 3) m_ph = 0;
            else if (m_ph == 0) begin if (want != 0) m_ph = 1; end
            else if (m_ph == 1) begin if (m_cnt == N - 1) m_ph = (want != 0) ? 3 : 2; end
            else if (m_ph == 2) begin if (want != 0) m_ph = 3; end
            else if (m_ph == 3) m_ph = 4;
            else if (adc_done) m_ph = (want != 0) ? 3 : 2;
            m_cnt = (old_ph == 1) ? ((m_cnt < N - 1) ? m_cnt + 1 : m_cnt) : 0;
            m_mode = want;
        end
    end

    // Converter stand-in: done pulses LAT cycles after each start; stray pulses on request.
    int cd = 0;
    always @(negedge clk) begin
        adc_done = 1'b0;
        if (cd > 0) begin
            cd--;
            if (cd == 0) adc_done = 1'b1;
        end
        if (stray_req != stray_seen) begin
            stray_seen = stray_req;
            adc_done = 1'b1;
        end
        if (adc_start) cd = LAT;
    end

    // Per-cycle comparison with the model, event counters, watchdog.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(adc_pwr_en == (m_ph != 0), "R8 model pwr_en", adc_pwr_en, m_ph != 0);
            chk(adc_start == (m_ph == 3), "R10 model adc_start", adc_start, m_ph == 3);
            chk(data_rdy == m_rdy, "R9 model data_rdy", data_rdy, m_rdy);
            chk(int'(mode_rd) == m_mode, "R7 model mode_rd", mode_rd, m_mode);
            if (adc_pwr_en && !prev_pwr) begin rise_cyc = cyc; gap_armed = 1; end
            if (adc_start) begin
                n_start++;
                if (gap_armed) begin last_gap = cyc - rise_cyc; gap_armed = 0; end
            end
            if (data_rdy) n_rdy++;
            prev_pwr = adc_pwr_en;
        end
        if (cyc > 150000 && !finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] code);
        @(negedge clk);
        mode_wr = 1'b1;
        mode_wdata = code;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int s0, r0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk(adc_pwr_en == 0, "R1 pwr_en", adc_pwr_en, 0);
        chk(mode_rd == 2'b11, "R1 mode_rd", mode_rd, 3);
        chk(adc_start == 0 && data_rdy == 0, "R1 start/rdy", adc_start, 0);

        // R2/R3 single request from off
        s0 = n_start; r0 = n_rdy;
        wr(2'b01);
        chk(adc_pwr_en == 1, "R2 pwr_en after wake", adc_pwr_en, 1);
        idle(N + 20);
        chk(n_start - s0 == 1, "R2 one start", n_start - s0, 1);
        chk(n_rdy - r0 == 1, "R2 one data_rdy", n_rdy - r0, 1);
        chk(last_gap == N, "R3 settle gap", last_gap, N);
        chk(mode_rd == 2'b00, "R7 mode after single", mode_rd, 0);
        chk(adc_pwr_en == 1, "R7 still powered", adc_pwr_en, 1);

        // R4 back-to-back singles, no settle
        wr(2'b01);
        chk(adc_start == 1, "R4 immediate start", adc_start, 1);
        idle(10);
        wr(2'b01);
        chk(adc_start == 1, "R4 second immediate start", adc_start, 1);
        idle(10);

        // R9 stray done while idle
        r0 = n_rdy;
        stray_req++;
        idle(5);
        chk(n_rdy - r0 == 0, "R9 stray done ignored", n_rdy - r0, 0);

        // R6 idle write while on, then R8 off, then idle write while off
        wr(2'b00);
        idle(5);
        chk(adc_pwr_en == 1 && mode_rd == 2'b00, "R6 idle stays powered", mode_rd, 0);
        wr(2'b11);
        chk(adc_pwr_en == 0, "R8 power drop", adc_pwr_en, 0);
        wr(2'b00);
        idle(3);
        chk(mode_rd == 2'b11, "R6 idle ignored when off", mode_rd, 3);
        chk(adc_pwr_en == 0, "R6 stays off", adc_pwr_en, 0);

        // R5 continuous from off
        s0 = n_start; r0 = n_rdy;
        wr(2'b10);
        idle(N + 40);
        chk(last_gap == N, "R5 settle before continuous", last_gap, N);
        chk(n_rdy - r0 >= 3, "R5 repeated sequences", n_rdy - r0, 3);
        // R6 stop continuous with idle
        wr(2'b00);
        idle(10);
        s0 = n_start; r0 = n_rdy;
        idle(20);
        chk(n_start - s0 == 0, "R6 no start after idle", n_start - s0, 0);
        chk(adc_pwr_en == 1, "R6 powered in idle", adc_pwr_en, 1);

        // R8 abort mid-conversion
        wr(2'b10);
        idle(2);
        while (!adc_start) @(negedge clk);
        idle(1);
        wr(2'b11);
        r0 = n_rdy;
        idle(10);
        chk(n_rdy - r0 == 0, "R8 no rdy after abort", n_rdy - r0, 0);
        chk(adc_pwr_en == 0, "R8 off after abort", adc_pwr_en, 0);

        // R8 settle cancel and restart from zero
        wr(2'b01);
        idle(N / 2);
        wr(2'b11);
        chk(adc_start == 0 && adc_pwr_en == 0, "R8 cancel settle", adc_pwr_en, 0);
        s0 = n_start;
        wr(2'b01);
        idle(N + 20);
        chk(last_gap == N, "R8 full settle after cancel", last_gap, N);
        chk(n_start - s0 == 1, "R8 single after cancel", n_start - s0, 1);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule